// File: doc/BRIEF.md
# Accumulating Early/Late Phase Detector

This block watches a reference signal (a data stream or a clock) from the clock domain of a local oscillator. It tells a digital loop which way to steer that oscillator, and by how much. The reference first crosses into the oscillator domain through a short synchronizer. It then feeds a three-sample window: A is the newest sample, T the one before it and B the oldest.

Each cycle, the window is classified as an early vote, a late vote or no vote. The two kinds of vote are counted in two separate saturating counters. A loop controller pulses the window-clear strobe once per update interval. On that strobe the block captures the difference of the two counts as a signed error word and starts a new interval.

Counting over an interval, rather than passing one vote per clock, lets a slow loop update, such as one that drives a serial DAC, see the net drift since its last update. The loop filter, the DAC link and the oscillator are outside this block.

Top module: `phase_accum_detector`

## Requirements
- R1: After reset, `phase_err` reads 0, and the first clear strobe with a quiet reference captures 0.
- R2: With the default two synchronizer stages, a reference value sampled at clock edge j enters A at edge j+2. A window whose newest sample was taken at edge j adds its vote to a counter at edge j+4.
- R3: An up vote is counted when A differs from T and T equals B.
- R4: A down vote is counted when A equals T and T differs from B.
- R5: No vote is counted when A equals B. Up and down votes are never counted in the same cycle, so a reference that toggles every cycle adds nothing.
- R6: `phase_err` changes only at a clock edge where `win_clr` is 1. It then takes the up count minus the down count, as a two's-complement word one bit wider than a counter. It holds that value until the next strobe.
- R7: A clear strobe restarts both counters. A vote arriving at the same edge becomes the first count of the new interval (value 1), so no vote is lost or counted twice.
- R8: Each counter stops at its full-scale value (all ones, 2^CNT_W-1) and does not wrap within one interval.
- R9: A synchronous active-high reset clears the synchronizer, the sample window, the vote registers, both counters and `phase_err`, whatever the reference is doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| win_clr | input | 1 | Interval strobe: capture the error and restart the counters |
| phase_err | output | CNT_W+1 | Signed error word, up count minus down count |

## Verification
The corner cases are:

- **Clear strobes that land on the very cycle a vote arrives.** These include back-to-back one-cycle intervals. A design that zeroed its counters outright would drop that vote, and one that kept counting the old value would carry it into the wrong interval.
- **Long intervals of a four-cycle square wave cut at arbitrary points.** Both counts run past full scale here. A wrapping counter would report a small bogus error instead of the difference of two saturated counts.
- **A reference that toggles every cycle, or is held constant.** Both must yield zero. A decode that ignored the A-equals-B rule would accumulate spurious votes.
- **A reset in mid-stream with the reference held high.** This shows whether any stale sample leaks into the first interval after reset.

The error word is compared against an arithmetic model on every cycle, so a capture that fires without a strobe is caught as well.

// File: rtl/phase_accum_pkg.sv
package phase_accum_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE = 2'd0,
    VOTE_UP   = 2'd1,
    VOTE_DN   = 2'd2
  } vote_e;

  // a: newest sample, t: middle, b: oldest
  function automatic vote_e classify(input logic a, input logic t, input logic b);
    if (a == b)      return VOTE_NONE;
    else if (a != t) return VOTE_UP;
    else             return VOTE_DN;
  endfunction

endpackage

// File: rtl/ref_sampler.sv
module ref_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic samp_a,
  output logic samp_t,
  output logic samp_b
);

  localparam int WIN = 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ref_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
  end

  assign samp_a = win_q[0];
  assign samp_t = win_q[1];
  assign samp_b = win_q[2];

endmodule

// File: rtl/vote_decode.sv
module vote_decode
  import phase_accum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic samp_a,
  input  logic samp_t,
  input  logic samp_b,
  output logic up_q,
  output logic dn_q
);

  vote_e vote;

  always_comb vote = classify(samp_a, samp_t, samp_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= (vote == VOTE_UP);
      dn_q <= (vote == VOTE_DN);
    end
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] FULL = '1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (clr)
      cnt <= {{(W-1){1'b0}}, inc};
    else if (inc && cnt != FULL)
      cnt <= cnt + {{(W-1){1'b0}}, 1'b1};
  end

endmodule

// File: rtl/phase_accum_detector.sv
module phase_accum_detector #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             win_clr,
  output logic [CNT_W:0]   phase_err
);

  localparam int ERR_W  = CNT_W + 1;
  localparam int N_DIRS = 2;

  logic             samp_a, samp_t, samp_b;
  logic             up_q, dn_q;
  logic [N_DIRS-1:0] vote_bus;
  logic [CNT_W-1:0] cnt_arr [N_DIRS];
  logic [CNT_W-1:0] up_cnt, dn_cnt;

  ref_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_in),
    .samp_a (samp_a),
    .samp_t (samp_t),
    .samp_b (samp_b)
  );

  vote_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .samp_a (samp_a),
    .samp_t (samp_t),
    .samp_b (samp_b),
    .up_q   (up_q),
    .dn_q   (dn_q)
  );

  assign vote_bus = {dn_q, up_q};

  generate
    for (genvar d = 0; d < N_DIRS; d++) begin : g_cnt
      sat_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (win_clr),
        .inc (vote_bus[d]),
        .cnt (cnt_arr[d])
      );
    end
  endgenerate

  assign up_cnt = cnt_arr[0];
  assign dn_cnt = cnt_arr[1];

  always_ff @(posedge clk) begin
    if (rst)
      phase_err <= '0;
    else if (win_clr)
      phase_err <= ERR_W'({1'b0, up_cnt}) - ERR_W'({1'b0, dn_cnt});
  end

endmodule

// File: rtl/phase_accum_detector_chk.sv
module phase_accum_detector_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             win_clr,
  input logic             samp_a,
  input logic             samp_t,
  input logic             samp_b,
  input logic             up_q,
  input logic             dn_q,
  input logic [CNT_W-1:0] up_cnt,
  input logic [CNT_W-1:0] dn_cnt,
  input logic [CNT_W:0]   phase_err
);

  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assert_up_R3: assert property (@(posedge clk) disable iff (rst)
    (samp_a != samp_t && samp_t == samp_b) |=> up_q);

  assert_dn_R4: assert property (@(posedge clk) disable iff (rst)
    (samp_a == samp_t && samp_t != samp_b) |=> dn_q);

  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (samp_a == samp_b) |=> (!up_q && !dn_q));

  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(up_q && dn_q));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !win_clr |=> $stable(phase_err));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    win_clr |=> (up_cnt <= ONE && dn_cnt <= ONE));

  assert_sat_up_R8: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == FULL && !win_clr) |=> up_cnt == FULL);

  assert_sat_dn_R8: assert property (@(posedge clk) disable iff (rst)
    (dn_cnt == FULL && !win_clr) |=> dn_cnt == FULL);

  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    !win_clr |=> (up_cnt == $past(up_cnt) || up_cnt == $past(up_cnt) + ONE));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (phase_err == '0 && up_cnt == '0 && dn_cnt == '0 && !up_q && !dn_q));

endmodule

bind phase_accum_detector phase_accum_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win_clr   (win_clr),
  .samp_a    (samp_a),
  .samp_t    (samp_t),
  .samp_b    (samp_b),
  .up_q      (up_q),
  .dn_q      (dn_q),
  .up_cnt    (up_cnt),
  .dn_cnt    (dn_cnt),
  .phase_err (phase_err)
);

// File: tb/phase_accum_detector_test.sv
module phase_accum_detector_test;

  localparam int CW   = 4;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_in = 1'b0;
  logic          win_clr = 1'b0;
  logic [CW:0]   phase_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state: h[k] = reference value sampled k edges ago
  logic h [7];
  int   m_up = 0, m_dn = 0, m_err = 0;
  bit   last_clr = 0;
  string last_tag = "R1";
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  phase_accum_detector #(.CNT_W(CW)) uut (
    .clk       (clk),
    .rst       (rst),
    .ref_in    (ref_in),
    .win_clr   (win_clr),
    .phase_err (phase_err)
  );

  function automatic int rnd(input int range);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed % range);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare the captured word with the model, then drive one cycle
  task automatic tick(input logic r, input logic c, input string tag);
    logic pu, pd;
    @(negedge clk);
    check($signed(phase_err) == m_err, last_clr ? last_tag : "R6 hold",
          int'($signed(phase_err)), m_err);
    ref_in  = r;
    win_clr = c;
    @(posedge clk);
    for (int k = 6; k > 0; k--) h[k] = h[k-1];
    h[0] = r;
    // R2: a window whose newest sample is 4 edges old reaches the counters now
    pu = (h[4] != h[5]) && (h[5] == h[6]);   // R3
    pd = (h[4] == h[5]) && (h[5] != h[6]);   // R4
    if (c) begin
      m_err = m_up - m_dn;                   // R6
      m_up  = int'(pu);                      // R7
      m_dn  = int'(pd);
    end else begin
      m_up = (m_up + int'(pu) > FULL) ? FULL : m_up + int'(pu);   // R8
      m_dn = (m_dn + int'(pd) > FULL) ? FULL : m_dn + int'(pd);
    end
    last_clr = c;
    last_tag = tag;
  endtask

  task automatic do_reset(input logic r, input int n);
    @(negedge clk);
    rst = 1'b1;
    ref_in = r;
    win_clr = 1'b0;
    repeat (n) @(posedge clk);
    for (int k = 0; k < 7; k++) h[k] = 1'b0;
    m_up = 0; m_dn = 0; m_err = 0;
    last_clr = 0;
    @(negedge clk);
    check(phase_err == '0, "R9 reset clears error", int'(phase_err), 0);
    rst = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 7; k++) h[k] = 1'b0;
    do_reset(1'b0, 3);

    // R1: first interval after reset with a quiet reference
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, "R1");
    tick(1'b0, 1'b1, "R1 quiet first capture");
    tick(1'b0, 1'b0, "R1");

    // R5: toggle every cycle, then constant high
    for (int i = 0; i < 30; i++) tick(logic'(i % 2), 1'b0, "R5");
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, "R5");
    tick(1'b1, 1'b1, "R5 toggle stream captures zero");
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, "R5");
    tick(1'b1, 1'b1, "R5 constant captures zero");

    // R7: one-cycle intervals across isolated edges
    for (int i = 0; i < 40; i++) tick(logic'((i / 5) % 2), 1'b1, "R7 one-cycle windows");

    // R2 R3 R4 R6: random bits, random interval lengths
    for (int w = 0; w < 120; w++) begin
      int len = 1 + rnd(24);
      for (int i = 0; i < len - 1; i++) tick(logic'(rnd(2)), 1'b0, "R3 R4 random");
      tick(logic'(rnd(2)), 1'b1, "R2 R3 R4 R6 random capture");
    end

    // R3 R4: run-length stream, runs of 1..6
    begin
      logic lvl = 1'b0;
      for (int w = 0; w < 60; w++) begin
        int runs = 1 + rnd(5);
        for (int k = 0; k < runs; k++) begin
          int rl = 1 + rnd(6);
          lvl = ~lvl;
          for (int i = 0; i < rl; i++) tick(lvl, 1'b0, "R3 R4 runs");
        end
        tick(lvl, 1'b1, "R3 R4 run-length capture");
      end
    end

    // R8: four-cycle square wave, long intervals cut anywhere
    for (int w = 0; w < 30; w++) begin
      int len = 60 + rnd(40);
      for (int i = 0; i < len; i++) tick(logic'((i / 2) % 2), 1'b0, "R8");
      tick(logic'((len / 2) % 2), 1'b1, "R8 saturated capture");
    end

    // R9: reset in mid-stream with the reference high
    for (int i = 0; i < 9; i++) tick(logic'(rnd(2)), 1'b0, "R9");
    do_reset(1'b1, 2);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, "R9");
    tick(1'b1, 1'b1, "R9 no stale vote after reset");
    tick(1'b1, 1'b0, "R9");
    tick(1'b1, 1'b0, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule